// File: doc/BRIEF.md
# Two-Bank Level Interrupt Aggregator

The block takes 64 level-sensitive peripheral interrupt lines and 8 core-local lines and drives one normal interrupt and one fast interrupt toward a processor. Software sees the lines through a 32-bit register port. The masked pending state of each peripheral half and a summary word are readable. The summary word carries the masked core-local lines, one flag for each peripheral half and copies of eleven chosen peripheral lines. Enables are never written directly. One set of registers turns enable bits on and a second set turns them off, so that two drivers sharing the block cannot undo each other's changes.

The fast interrupt takes its source from a 7-bit selector. It follows the raw level of the line the selector names and ignores the enables. Both outputs leave flops, so any change of input, enable or control appears at the pins one clock later. The register port is a valid/write/address/data strobe. Read data is registered and is returned the cycle after the request.

Top module: `irq_fold_ctrl`

## Requirements
- R1: After a synchronous reset all enables, the fast selector and the fast enable are zero. Both outputs are low and read data is zero.
- R2: A write to 0x10 ORs the data into peripheral enables 31:0, a write to 0x14 into enables 63:32, and a write to 0x18 ORs data bits 7:0 into the core-local enables. Reading these offsets returns the enables, with the core-local value zero-extended.
- R3: A write to 0x1C, 0x20 or 0x24 clears each enable of the same bank whose data bit is one. Reading these offsets returns the bitwise inverse of the zero-extended enables, so a core-local read has bits 31:8 set.
- R4: Offsets 0x04 and 0x08 read the peripheral levels ANDed with their enables, lines 31:0 and 63:32. Writes to 0x00, 0x04 and 0x08 change no state.
- R5: Summary word 0x00 holds the masked core-local lines in bits 7:0. Bit 8 is set when any enabled peripheral line 31:0 is high, and bit 9 when any enabled line 63:32 is high.
- R6: Summary bits 10 to 20 are, in this order, the masked pending state of peripheral lines 7, 9, 10, 18, 19, 53, 54, 55, 56, 57 and 62. Bits 31:21 read zero.
- R7: Offset 0x0C holds the fast selector in bits 6:0 and the fast enable in bit 7. It reads back in the same positions with bits 31:8 zero.
- R8: With the fast enable set, selector values 0 to 63 route peripheral line n to the fast output, values 64 to 71 route core-local line n-64, and values 72 to 127 give a low output. The enables do not affect this path. With the fast enable clear the output is low.
- R9: The normal output is high exactly when some peripheral or core-local line is high while its enable is set.
- R10: Each output is the value computed from the inputs and state sampled at the previous rising clock edge.
- R11: A read returns its data on bus_rdata after the rising edge that samples the request. Reads of unmapped or misaligned offsets return zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| periph_lvl | input | 64 | Peripheral interrupt levels |
| core_lvl | input | 8 | Core-local interrupt levels |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_out | output | 1 | Normal interrupt output |
| fiq_out | output | 1 | Fast interrupt output |

## Verification
The hardest case to reach is a fast route that picks the wrong line. With only one line driven, many miswired selectors still look correct. The bench sweeps all 128 selector values with every enable cleared. For each value it drives first only the named line high and then every line except that one. A route off by one index or one bank shows up in one of the two patterns, and values above 71 must stay low under both.

// File: rtl/irq_fold_pkg.sv
package irq_fold_pkg;
  // Number of peripheral lines mirrored into the summary word.
  localparam int FOLD_COUNT = 11;

  // Peripheral line mirrored into summary fold slot idx.
  function automatic int fold_src(input int idx);
    case (idx)
      0: return 7;
      1: return 9;
      2: return 10;
      3: return 18;
      4: return 19;
      5: return 53;
      6: return 54;
      7: return 55;
      8: return 56;
      9: return 57;
      default: return 62;
    endcase
  endfunction

  // Word index order follows the register offsets (offset = 4 * index).
  typedef enum logic [3:0] {
    RG_SUMMARY  = 4'd0,
    RG_PEND_LO  = 4'd1,
    RG_PEND_HI  = 4'd2,
    RG_FAST     = 4'd3,
    RG_SET_LO   = 4'd4,
    RG_SET_HI   = 4'd5,
    RG_SET_CORE = 4'd6,
    RG_CLR_LO   = 4'd7,
    RG_CLR_HI   = 4'd8,
    RG_CLR_CORE = 4'd9,
    RG_NONE     = 4'd15
  } reg_sel_e;

  localparam int REG_WORDS = 10;
endpackage

// File: rtl/irq_enable_bank.sv
module irq_enable_bank #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_en,
  input  logic             clr_en,
  input  logic [WIDTH-1:0] mask,
  output logic [WIDTH-1:0] en
);
  always_ff @(posedge clk) begin
    if (rst)          en <= '0;
    else if (set_en)  en <= en | mask;
    else if (clr_en)  en <= en & ~mask;
  end

  // R2
  set_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (set_en && !clr_en) |=> ((en & $past(mask)) == $past(mask)));

  // R3
  clr_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_en && !set_en) |=> ((en & $past(mask)) == '0));
endmodule

// File: rtl/irq_summary_fold.sv
module irq_summary_fold
  import irq_fold_pkg::*;
#(
  parameter int PERIPH_LINES = 64,
  parameter int CORE_LINES   = 8,
  parameter int DATA_W       = 32
) (
  input  logic [PERIPH_LINES-1:0] periph_pend,
  input  logic [CORE_LINES-1:0]   core_pend,
  output logic [DATA_W-1:0]       summary
);
  localparam int HALF   = PERIPH_LINES / 2;
  localparam int USED_W = CORE_LINES + 2 + FOLD_COUNT;

  logic [FOLD_COUNT-1:0] fold_bits;

  for (genvar k = 0; k < FOLD_COUNT; k++) begin : g_fold
    assign fold_bits[k] = periph_pend[fold_src(k)];
  end

  logic lo_any, hi_any;
  assign lo_any = |periph_pend[HALF-1:0];
  assign hi_any = |periph_pend[PERIPH_LINES-1:HALF];

  always_comb begin
    summary = '0;
    summary[USED_W-1:0] = {fold_bits, hi_any, lo_any, core_pend};
  end
endmodule

// File: rtl/irq_fast_route.sv
module irq_fast_route #(
  parameter int PERIPH_LINES = 64,
  parameter int CORE_LINES   = 8,
  parameter int SEL_W        = 7
) (
  input  logic                    on,
  input  logic [SEL_W-1:0]        sel,
  input  logic [PERIPH_LINES-1:0] periph_lvl,
  input  logic [CORE_LINES-1:0]   core_lvl,
  output logic                    hit
);
  always_comb begin
    hit = 1'b0;
    for (int i = 0; i < PERIPH_LINES; i++)
      if (int'(sel) == i) hit = periph_lvl[i];
    for (int j = 0; j < CORE_LINES; j++)
      if (int'(sel) == PERIPH_LINES + j) hit = core_lvl[j];
    if (!on) hit = 1'b0;
  end
endmodule

// File: rtl/irq_fold_ctrl.sv
module irq_fold_ctrl
  import irq_fold_pkg::*;
#(
  parameter int PERIPH_LINES = 64,
  parameter int CORE_LINES   = 8,
  parameter int DATA_W       = 32,
  parameter int ADDR_W       = 8,
  parameter int SEL_W        = 7
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [PERIPH_LINES-1:0] periph_lvl,
  input  logic [CORE_LINES-1:0]   core_lvl,
  input  logic                    bus_valid,
  input  logic                    bus_write,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [DATA_W-1:0]       bus_wdata,
  output logic [DATA_W-1:0]       bus_rdata,
  output logic                    irq_out,
  output logic                    fiq_out
);
  localparam int HALF   = PERIPH_LINES / 2;
  localparam int WORD_W = ADDR_W - 2;
  localparam int ROUTES = PERIPH_LINES + CORE_LINES;

  // ---------------- address decode ----------------
  logic [WORD_W-1:0] word_idx;
  reg_sel_e          reg_sel;

  always_comb begin
    word_idx = bus_addr[ADDR_W-1:2];
    reg_sel  = RG_NONE;
    if (bus_addr[1:0] == 2'b00 && word_idx < WORD_W'(REG_WORDS))
      reg_sel = reg_sel_e'(word_idx[3:0]);
  end

  logic wr_go, rd_go;
  assign wr_go = bus_valid && bus_write;
  assign rd_go = bus_valid && !bus_write;

  // ---------------- enable banks ----------------
  logic [PERIPH_LINES-1:0] pen, pmask;
  logic [CORE_LINES-1:0]   cen;
  logic p_set, p_clr, c_set, c_clr;

  assign p_set = wr_go && (reg_sel == RG_SET_LO || reg_sel == RG_SET_HI);
  assign p_clr = wr_go && (reg_sel == RG_CLR_LO || reg_sel == RG_CLR_HI);
  assign c_set = wr_go && (reg_sel == RG_SET_CORE);
  assign c_clr = wr_go && (reg_sel == RG_CLR_CORE);

  always_comb begin
    pmask = '0;
    if (reg_sel == RG_SET_HI || reg_sel == RG_CLR_HI)
      pmask[PERIPH_LINES-1:HALF] = bus_wdata[HALF-1:0];
    else
      pmask[HALF-1:0] = bus_wdata[HALF-1:0];
  end

  irq_enable_bank #(.WIDTH(PERIPH_LINES)) u_periph_en (
    .clk(clk), .rst(rst), .set_en(p_set), .clr_en(p_clr),
    .mask(pmask), .en(pen)
  );

  irq_enable_bank #(.WIDTH(CORE_LINES)) u_core_en (
    .clk(clk), .rst(rst), .set_en(c_set), .clr_en(c_clr),
    .mask(bus_wdata[CORE_LINES-1:0]), .en(cen)
  );

  // ---------------- fast control ----------------
  logic [SEL_W-1:0] fast_sel;
  logic             fast_on;

  always_ff @(posedge clk) begin
    if (rst) begin
      fast_sel <= '0;
      fast_on  <= 1'b0;
    end else if (wr_go && reg_sel == RG_FAST) begin
      fast_sel <= bus_wdata[SEL_W-1:0];
      fast_on  <= bus_wdata[SEL_W];
    end
  end

  logic fast_hit;
  irq_fast_route #(
    .PERIPH_LINES(PERIPH_LINES), .CORE_LINES(CORE_LINES), .SEL_W(SEL_W)
  ) u_route (
    .on(fast_on), .sel(fast_sel), .periph_lvl(periph_lvl),
    .core_lvl(core_lvl), .hit(fast_hit)
  );

  // ---------------- pending and summary ----------------
  logic [PERIPH_LINES-1:0] ppend;
  logic [CORE_LINES-1:0]   cpend;
  logic [DATA_W-1:0]       summary;

  assign ppend = periph_lvl & pen;
  assign cpend = core_lvl & cen;

  irq_summary_fold #(
    .PERIPH_LINES(PERIPH_LINES), .CORE_LINES(CORE_LINES), .DATA_W(DATA_W)
  ) u_fold (
    .periph_pend(ppend), .core_pend(cpend), .summary(summary)
  );

  // ---------------- read mux ----------------
  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    case (reg_sel)
      RG_SUMMARY:  rd_mux = summary;
      RG_PEND_LO:  rd_mux = DATA_W'(ppend[HALF-1:0]);
      RG_PEND_HI:  rd_mux = DATA_W'(ppend[PERIPH_LINES-1:HALF]);
      RG_FAST:     rd_mux = DATA_W'({fast_on, fast_sel});
      RG_SET_LO:   rd_mux = DATA_W'(pen[HALF-1:0]);
      RG_SET_HI:   rd_mux = DATA_W'(pen[PERIPH_LINES-1:HALF]);
      RG_SET_CORE: rd_mux = DATA_W'(cen);
      RG_CLR_LO:   rd_mux = ~DATA_W'(pen[HALF-1:0]);
      RG_CLR_HI:   rd_mux = ~DATA_W'(pen[PERIPH_LINES-1:HALF]);
      RG_CLR_CORE: rd_mux = ~DATA_W'(cen);
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        bus_rdata <= '0;
    else if (rd_go) bus_rdata <= rd_mux;
  end

  // ---------------- registered outputs ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_out <= 1'b0;
      fiq_out <= 1'b0;
    end else begin
      irq_out <= (|ppend) || (|cpend);
      fiq_out <= fast_hit;
    end
  end

  // ---------------- assertions ----------------
  // R9
  irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (periph_lvl == '0 && core_lvl == '0) |=> !irq_out);

  // R9
  irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
    (pen == '0 && cen == '0) |=> !irq_out);

  // R8
  fiq_off_chk: assert property (@(posedge clk) disable iff (rst)
    !fast_on |=> !fiq_out);

  // R8
  fiq_range_chk: assert property (@(posedge clk) disable iff (rst)
    (fast_on && int'(fast_sel) >= ROUTES) |=> !fiq_out);

  // R11
  unmapped_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_go && reg_sel == RG_NONE) |=> (bus_rdata == '0));

  // R4
  pend_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_go && (reg_sel == RG_SUMMARY || reg_sel == RG_PEND_LO ||
               reg_sel == RG_PEND_HI))
    |=> ($stable(pen) && $stable(cen) && $stable(fast_sel) && $stable(fast_on)));
endmodule

// File: tb/irq_fold_ctrl_bench.sv
`timescale 1ns/1ps
module irq_fold_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] periph_lvl = '0;
  logic [7:0]  core_lvl = '0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_out, fiq_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  irq_fold_ctrl u_irq_fold_ctrl (
    .clk(clk), .rst(rst), .periph_lvl(periph_lvl), .core_lvl(core_lvl),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_out(irq_out), .fiq_out(fiq_out)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_valid = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(req, {32'h0, d}, {32'h0, exp});
  endtask

  function automatic logic [31:0] exp_summary(input logic [63:0] pp, input logic [7:0] cp);
    int fl[11] = '{7, 9, 10, 18, 19, 53, 54, 55, 56, 57, 62};
    logic [31:0] s = '0;
    s[7:0] = cp;
    s[8] = (pp[31:0] != 0);
    s[9] = (pp[63:32] != 0);
    for (int k = 0; k < 11; k++) s[10 + k] = pp[fl[k]];
    return s;
  endfunction

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected finished");
      report();
    end
  end

  initial begin
    logic [63:0] pp, pe;
    logic [7:0]  cp, ce;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 irq_out", {63'h0, irq_out}, 64'h0);
    check("R1 fiq_out", {63'h0, fiq_out}, 64'h0);
    check("R1 rdata", {32'h0, bus_rdata}, 64'h0);
    rd_chk("R1 en lo", 8'h10, 32'h0);
    rd_chk("R1 en hi", 8'h14, 32'h0);
    rd_chk("R1 en core", 8'h18, 32'h0);
    rd_chk("R1 fast ctrl", 8'h0C, 32'h0);
    rd_chk("R1 clr core view", 8'h24, 32'hFFFF_FFFF);

    // R2 set registers OR in
    wr(8'h10, 32'hA5A5_0F0F);
    wr(8'h10, 32'h0000_F000);
    rd_chk("R2 en lo or", 8'h10, 32'hA5A5_FF0F);
    wr(8'h14, 32'h1234_0000);
    rd_chk("R2 en hi", 8'h14, 32'h1234_0000);
    rd_chk("R2 en lo untouched", 8'h10, 32'hA5A5_FF0F);
    wr(8'h18, 32'hFFFF_FF3C);
    rd_chk("R2 core low byte", 8'h18, 32'h0000_003C);

    // R3 clear registers and inverted views
    wr(8'h1C, 32'h0000_0F00);
    rd_chk("R3 en lo cleared", 8'h10, 32'hA5A5_F00F);
    rd_chk("R3 clr lo view", 8'h1C, ~32'hA5A5_F00F);
    wr(8'h20, 32'h0034_0000);
    rd_chk("R3 en hi cleared", 8'h14, 32'h1200_0000);
    rd_chk("R3 clr hi view", 8'h20, ~32'h1200_0000);
    wr(8'h24, 32'h0000_000C);
    rd_chk("R3 core cleared", 8'h18, 32'h0000_0030);
    rd_chk("R3 clr core view", 8'h24, 32'hFFFF_FFCF);

    // enable everything
    wr(8'h10, 32'hFFFF_FFFF);
    wr(8'h14, 32'hFFFF_FFFF);
    wr(8'h18, 32'h0000_00FF);

    // R10 output latency
    @(negedge clk);
    check("R10 irq idle", {63'h0, irq_out}, 64'h0);
    periph_lvl = 64'h20;
    #1 check("R10 irq before edge", {63'h0, irq_out}, 64'h0);
    @(negedge clk);
    check("R10 irq after edge", {63'h0, irq_out}, 64'h1);
    periph_lvl = '0;
    @(negedge clk);
    check("R10 irq drop", {63'h0, irq_out}, 64'h0);

    // R4 R5 R6 R9 single peripheral line sweep
    for (int i = 0; i < 64; i++) begin
      periph_lvl = 64'h1 << i;
      @(negedge clk);
      check("R9 single line irq", {63'h0, irq_out}, 64'h1);
      rd_chk("R4 pend lo", 8'h04, periph_lvl[31:0]);
      rd_chk("R4 pend hi", 8'h08, periph_lvl[63:32]);
      rd_chk("R6 summary fold", 8'h00, exp_summary(periph_lvl, 8'h0));
    end
    periph_lvl = '0;

    // R5 core-local sweep
    for (int j = 0; j < 8; j++) begin
      core_lvl = 8'h1 << j;
      @(negedge clk);
      check("R9 core line irq", {63'h0, irq_out}, 64'h1);
      rd_chk("R5 summary core", 8'h00, exp_summary(64'h0, core_lvl));
    end
    core_lvl = '0;

    // R4 R5 R6 R9 masked patterns
    for (int k = 1; k <= 8; k++) begin
      pp = 64'h9E37_79B9_7F4A_7C15 * k;
      pe = 64'hC2B2_AE3D_27D4_EB4F * (k + 3);
      cp = 8'(k * 37);
      ce = 8'(k * 91);
      if (k == 4) pe = ~pp;
      if (k == 4) ce = ~cp;
      wr(8'h1C, 32'hFFFF_FFFF);
      wr(8'h20, 32'hFFFF_FFFF);
      wr(8'h24, 32'hFFFF_FFFF);
      wr(8'h10, pe[31:0]);
      wr(8'h14, pe[63:32]);
      wr(8'h18, {24'h0, ce});
      periph_lvl = pp;
      core_lvl = cp;
      @(negedge clk);
      check("R9 masked irq", {63'h0, irq_out}, {63'h0, ((pp & pe) != 0) || ((cp & ce) != 0)});
      rd_chk("R4 masked lo", 8'h04, pp[31:0] & pe[31:0]);
      rd_chk("R4 masked hi", 8'h08, pp[63:32] & pe[63:32]);
      rd_chk("R5 masked summary", 8'h00, exp_summary(pp & pe, cp & ce));
    end

    // R4 pending registers ignore writes
    wr(8'h04, 32'hFFFF_FFFF);
    wr(8'h08, 32'hFFFF_FFFF);
    wr(8'h00, 32'hFFFF_FFFF);
    rd_chk("R4 en lo after pend write", 8'h10, pe[31:0]);
    rd_chk("R4 en hi after pend write", 8'h14, pe[63:32]);
    rd_chk("R4 fast after pend write", 8'h0C, 32'h0);

    // R8 fast route sweep with masks cleared
    wr(8'h1C, 32'hFFFF_FFFF);
    wr(8'h20, 32'hFFFF_FFFF);
    wr(8'h24, 32'hFFFF_FFFF);
    for (int s = 0; s < 128; s++) begin
      logic [71:0] onehot;
      onehot = (s < 72) ? (72'h1 << s) : 72'h0;
      wr(8'h0C, 32'h80 | s);
      {core_lvl, periph_lvl} = onehot;
      @(negedge clk);
      check("R8 fast target only", {63'h0, fiq_out}, {63'h0, (s < 72)});
      check("R9 masked off", {63'h0, irq_out}, 64'h0);
      {core_lvl, periph_lvl} = ~onehot;
      @(negedge clk);
      check("R8 fast all but target", {63'h0, fiq_out}, 64'h0);
      rd_chk("R7 fast readback", 8'h0C, 32'h80 | s);
    end

    // R8 fast disabled
    wr(8'h0C, 32'h0000_0003);
    periph_lvl = '1;
    core_lvl = '1;
    @(negedge clk);
    check("R8 fast disabled", {63'h0, fiq_out}, 64'h0);
    rd_chk("R7 fast readback off", 8'h0C, 32'h3);
    wr(8'h0C, 32'hFFFF_FF85);
    @(negedge clk);
    check("R8 fast line 5", {63'h0, fiq_out}, 64'h1);
    rd_chk("R7 upper bits dropped", 8'h0C, 32'h85);

    // R11 unmapped offsets
    rd_chk("R11 unmapped 0x28", 8'h28, 32'h0);
    rd_chk("R11 unmapped 0xFC", 8'hFC, 32'h0);
    rd_chk("R11 misaligned", 8'h12, 32'h0);
    wr(8'h28, 32'hFFFF_FFFF);
    wr(8'h11, 32'hFFFF_FFFF);
    rd_chk("R11 write ignored lo", 8'h10, 32'h0);
    rd_chk("R11 write ignored core", 8'h18, 32'h0);

    // R1 reset again mid-run
    wr(8'h10, 32'h1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    rd_chk("R1 en lo after reset", 8'h10, 32'h0);
    rd_chk("R1 fast after reset", 8'h0C, 32'h0);

    done = 1'b1;
    report();
  end
endmodule